// File: doc/BRIEF.md
# Redundant Reference Clock Failover

This block sits in front of a clock consumer that must keep receiving a reference even when one of its two sources dies. It takes a primary clock (`clk_a`, input 0) and a backup clock (`clk_b`, input 1). Each clock checks the other for activity. The monitoring side first halves the watched clock into a toggle. It then brings that toggle across a two-flop synchronizer and counts its own cycles between toggle transitions. When the count saturates, the bad flag of the watched input rises.

If the selected input is flagged while the other input still runs, the domain of the surviving clock moves the selection to itself. The output clock is switched by a two-enable handshake, so `clk_out` never glitches. A dead clock's enable is cleared asynchronously through its bad flag. A flag drops again once the input is seen toggling steadily, so switching can repeat any number of times.

Flag accuracy assumes the two periods are within 20% of each other. Outside that range only `active_sel` can be trusted. Both clocks must be running when reset is released, and a monitor starts counting only after its first observed transition.

Top module: `clk_failover`

## Requirements
- R1: While `rst_n` is low, `bad`=00, `active_sel`=0, `switch_pulse`=0 and `clk_out`=0. After release, `clk_out` carries `clk_a`.
- R2: `bad[0]` reflects `clk_a` and `bad[1]` reflects `clk_b`. Once an input stops, its flag is still low one cycle of the other clock later and is high within about 13 cycles of the other clock.
- R3: A raised flag clears after its input shows three transitions of its halved clock with no gap of `STALL_LIMIT` cycles between them.
- R4: When the selected input is flagged and the other input runs, the selection moves to the other input. `active_sel` is 0 for `clk_a` and 1 for `clk_b`.
- R5: When the standby input stops, its flag rises, `active_sel` stays unchanged and no switch pulse appears.
- R6: When the selected input stops while the other is also stopped, no switch takes place.
- R7: Switching repeats in both directions without limit.
- R8: Recovery of a previously failed input does not move the selection back.
- R9: Every change of `active_sel` comes with exactly one `switch_pulse`, one cycle of the newly selected clock long. No pulse appears otherwise.
- R10: After a switch, `clk_out` follows the selected input. The two gate enables are never both on, and the new enable rises only after the old one is off.
- R11: While an input is flagged, the monitor clocked by that input is held idle. Restarting it raises no false flag on the other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_a | input | 1 | Primary reference clock (input 0) |
| clk_b | input | 1 | Backup reference clock (input 1) |
| bad | output | 2 | Per-input stopped flag, bit n for input n |
| active_sel | output | 1 | Currently selected input |
| switch_pulse | output | 1 | One-cycle pulse on each selection change |
| clk_out | output | 1 | Glitch-free selected clock |

## Verification
The bound checker watches, on every edge of either clock, that the two gate enables are never on together. It also checks that a newly raised enable finds the other one off, that a domain changes its select bit only after it has seen the opposite input flagged, and that each switch pulse lasts one cycle and coincides with a select change. The bench scenarios cover what only whole sequences can show: flag timing relative to a stopped input, healing after restart, and the absence of a switch when the standby or both inputs die. They also show that no spurious flag appears while a dead clock restarts, that `clk_out` truly follows the chosen source, and that the order of switch events matches expectations.

// File: rtl/clk_failover.sv
`timescale 1ns/1ps
module clk_failover #(
  parameter int STALL_LIMIT  = 3,
  parameter int HEAL_TOGGLES = 3
) (
  input  logic       rst_n,
  input  logic       clk_a,
  input  logic       clk_b,
  output logic [1:0] bad,
  output logic       active_sel,
  output logic       switch_pulse,
  output logic       clk_out
);
  localparam int SW = $clog2(STALL_LIMIT + 1);
  localparam int HW = $clog2(HEAL_TOGGLES + 1);

  logic [1:0] clk_in, tog, own, en, pulse;
  assign clk_in = {clk_b, clk_a};

  for (genvar i = 0; i < 2; i++) begin : g_dom
    localparam int J = 1 - i;
    logic          tog_q, s_q, pulse_q, en_q, bad_q, armed, hit, mine, kill;
    logic [2:0]    seen;
    logic [1:0]    own_sync, en_sync, self_bad;
    logic [SW-1:0] stall;
    logic [HW-1:0] heal;

    always_ff @(posedge clk_in[i] or negedge rst_n)
      if (!rst_n) tog_q <= 1'b0;
      else        tog_q <= ~tog_q;

    // watch the other input's halved clock
    assign hit = seen[2] ^ seen[1];
    always_ff @(posedge clk_in[i] or negedge rst_n) begin
      if (!rst_n) begin
        seen     <= '0;
        self_bad <= '0;
        armed    <= 1'b0;
        stall    <= '0;
        heal     <= '0;
        bad_q    <= 1'b0;
      end else begin
        seen     <= {seen[1:0], tog[J]};
        self_bad <= {self_bad[0], bad[i]};
        if (self_bad[1]) begin
          armed <= 1'b0;
          stall <= '0;
        end else if (hit) begin
          armed <= 1'b1;
          stall <= '0;
          if (bad_q) begin
            if (heal == HW'(HEAL_TOGGLES - 1)) begin
              bad_q <= 1'b0;
              heal  <= '0;
            end else begin
              heal <= heal + 1'b1;
            end
          end
        end else if (armed && stall != SW'(STALL_LIMIT)) begin
          stall <= stall + 1'b1;
          if (stall == SW'(STALL_LIMIT - 1)) begin
            bad_q <= 1'b1;
            heal  <= '0;
          end
        end
      end
    end

    // select: this domain may only claim the selection for its own input
    assign mine = ((own[i] ^ own_sync[1]) == 1'(i));
    always_ff @(posedge clk_in[i] or negedge rst_n) begin
      if (!rst_n) begin
        s_q      <= 1'b0;
        pulse_q  <= 1'b0;
        own_sync <= '0;
        en_sync  <= '0;
      end else begin
        own_sync <= {own_sync[0], own[J]};
        en_sync  <= {en_sync[0], en[J]};
        pulse_q  <= !mine && bad_q;
        if (!mine && bad_q) s_q <= ~s_q;
      end
    end

    // gate enable, dropped at once when this input is declared dead
    assign kill = !rst_n || bad[i];
    always_ff @(negedge clk_in[i] or posedge kill)
      if (kill) en_q <= 1'b0;
      else      en_q <= mine && !en_sync[1];

    assign tog[i]   = tog_q;
    assign own[i]   = s_q;
    assign pulse[i] = pulse_q;
    assign en[i]    = en_q;
    assign bad[J]   = bad_q;
  end

  assign active_sel   = own[0] ^ own[1];
  assign switch_pulse = |pulse;
  assign clk_out      = |(clk_in & en);
endmodule

// File: rtl/clk_failover_chk.sv
`timescale 1ns/1ps
module clk_failover_chk (
  input logic       rst_n,
  input logic       clk_a,
  input logic       clk_b,
  input logic [1:0] bad,
  input logic [1:0] en,
  input logic [1:0] own,
  input logic [1:0] pulse
);
  // R10
  en_excl_a_chk: assert property (@(posedge clk_a) disable iff (!rst_n) !(en[0] && en[1]));
  // R10
  en_excl_b_chk: assert property (@(posedge clk_b) disable iff (!rst_n) !(en[0] && en[1]));
  // R10
  en_order_a_chk: assert property (@(posedge clk_a) disable iff (!rst_n) $rose(en[0]) |-> !en[1]);
  // R10
  en_order_b_chk: assert property (@(posedge clk_b) disable iff (!rst_n) $rose(en[1]) |-> !en[0]);
  // R4
  claim_a_chk: assert property (@(posedge clk_a) disable iff (!rst_n) !$stable(own[0]) |-> $past(bad[1]));
  // R4
  claim_b_chk: assert property (@(posedge clk_b) disable iff (!rst_n) !$stable(own[1]) |-> $past(bad[0]));
  // R9
  pulse_one_a_chk: assert property (@(posedge clk_a) disable iff (!rst_n) pulse[0] |=> !pulse[0]);
  // R9
  pulse_one_b_chk: assert property (@(posedge clk_b) disable iff (!rst_n) pulse[1] |=> !pulse[1]);
  // R9
  pulse_tie_a_chk: assert property (@(posedge clk_a) disable iff (!rst_n) pulse[0] |-> !$stable(own[0]));
  // R9
  pulse_tie_b_chk: assert property (@(posedge clk_b) disable iff (!rst_n) pulse[1] |-> !$stable(own[1]));
endmodule

bind clk_failover clk_failover_chk u_chk (
  .rst_n(rst_n), .clk_a(clk_a), .clk_b(clk_b), .bad(bad),
  .en(en), .own(own), .pulse(pulse)
);

// File: tb/sim_clk_failover.sv
`timescale 1ns/1ps
module sim_clk_failover;
  logic       rst_n, clk_a, clk_b;
  logic [1:0] bad;
  logic       active_sel, switch_pulse, clk_out;
  logic       run_a, run_b, hold_a, hold_b;
  int         checks, errors, npulse;
  bit         done;
  logic       exp_q[$];

  clk_failover u0 (
    .rst_n(rst_n), .clk_a(clk_a), .clk_b(clk_b), .bad(bad),
    .active_sel(active_sel), .switch_pulse(switch_pulse), .clk_out(clk_out)
  );

  initial begin
    clk_a = 1'b0;
    forever begin #2; if (run_a) clk_a = ~clk_a; else clk_a = hold_a; end
  end
  initial begin
    clk_b = 1'b0;
    forever begin #2.2; if (run_b) clk_b = ~clk_b; else clk_b = hold_b; end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_switch(logic v);
    exp_q.push_back(v);
  endtask

  // monitor: pops an expected selection for each pulse
  initial begin
    realtime t0;
    forever begin
      @(posedge switch_pulse);
      t0 = $realtime;
      npulse++;
      #0.5;
      if (exp_q.size() == 0) check("R9 unexpected switch pulse", 1, 0);
      else check("R4 selection after pulse", active_sel, exp_q.pop_front());
      @(negedge switch_pulse);
      check("R9 pulse one cycle wide", ($realtime - t0) < 5.0, 1);
    end
  end

  task automatic follow(int which, string tag);
    int bad_samples = 0;
    for (int k = 0; k < 4; k++) begin
      if (which == 0) @(posedge clk_a); else @(posedge clk_b);
      #0.5; if (clk_out !== 1'b1) bad_samples++;
      if (which == 0) @(negedge clk_a); else @(negedge clk_b);
      #0.5; if (clk_out !== 1'b0) bad_samples++;
    end
    check(tag, bad_samples, 0);
  endtask

  task automatic stay_low(int idx, string tag);
    int hits = 0;
    for (int k = 0; k < 30; k++) begin #10; if (bad[idx] !== 1'b0) hits++; end
    check(tag, hits, 0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run_a = 1'b1; run_b = 1'b1; hold_a = 1'b0; hold_b = 1'b0;
    #20;
    check("R1 bad in reset", bad, 0);
    check("R1 select in reset", active_sel, 0);
    check("R1 pulse in reset", switch_pulse, 0);
    check("R1 clk_out in reset", clk_out, 0);
    #30.3 rst_n = 1'b1;
    #200;
    check("R1 bad after release", bad, 0);
    check("R1 select after release", active_sel, 0);
    follow(0, "R1 clk_out carries clk_a");

    // standby failure
    run_b = 1'b0;
    #100;
    check("R5 standby flagged", bad, 2);
    check("R5 select kept", active_sel, 0);
    run_b = 1'b1;
    stay_low(0, "R11 no false flag on clk_a while clk_b restarts");
    check("R3 flag healed", bad, 0);
    check("R5 no switch", npulse, 0);

    // active failure, stuck low
    run_a = 1'b0;
    expect_switch(1'b1);
    #5;
    check("R2 flag not immediate", bad[0], 0);
    #55;
    check("R2 flag raised in time", bad[0], 1);
    #40;
    check("R4 moved to clk_b", active_sel, 1);
    check("R2 only clk_a flagged", bad, 1);
    follow(1, "R10 clk_out carries clk_b");

    // recovery of clk_a
    run_a = 1'b1;
    stay_low(1, "R11 no false flag on clk_b while clk_a restarts");
    check("R3 clk_a flag healed", bad, 0);
    check("R8 no switch back", active_sel, 1);

    // active failure, stuck high
    hold_b = 1'b1; run_b = 1'b0;
    expect_switch(1'b0);
    #100;
    check("R2 clk_b flagged", bad, 2);
    check("R4 moved to clk_a", active_sel, 0);
    follow(0, "R10 clk_out back on clk_a");
    hold_b = 1'b0; run_b = 1'b1;
    #300;
    check("R3 clk_b flag healed", bad, 0);

    // repeat switch
    run_a = 1'b0;
    expect_switch(1'b1);
    #100;
    check("R7 second move to clk_b", active_sel, 1);
    check("R7 clk_a flagged again", bad[0], 1);

    // both dead
    run_b = 1'b0;
    #300;
    check("R6 no switch with both stopped", active_sel, 1);
    check("R6 pulse count", npulse, 3);
    check("R9 every expected switch seen", exp_q.size(), 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule